// File: doc/BRIEF.md
# Stored-Word Adder Datapath

This block combines a small word memory with a carry-producing adder behind a single registered result port. On each clock cycle a two-bit operation code picks one of four actions: idle, store the incoming data word at the given address, fetch the word at that address, or fetch it and add the incoming data word to it. The memory and the adder are separate submodule instances. The memory has its own data-in and data-out ports. Its data-out feeds one adder operand and the result register.

The result register is one bit wider than a memory word. A fetch places the stored word in the low bits and zero in the top bit. An add places the full sum there, carry included. Idle and store cycles leave the result unchanged. The memory reads combinationally and is written on the rising edge, so a fetch or add issued right after a store to the same address sees the new word. Widths and depth are parameters, and a parameter selects either an explicit ripple-carry adder or a behavioural one.

Top module: `memadd_core`

## Requirements
- R1: A synchronous active-high reset sampled on a rising edge clears the result to zero at that edge. Memory contents are not cleared.
- R2: With op code 01 (store), the data input is written into the addressed word at the rising edge. The result keeps its previous value.
- R3: With op code 10 (fetch), the result after the next rising edge holds the addressed word in bits 3:0 and 0 in bit 4.
- R4: With op code 11 (add), the result after the next rising edge is the 5-bit sum of the addressed word and the data input, with the carry in bit 4. For example, 15 + 15 gives 30.
- R5: With op code 00 (idle), the result keeps its previous value.
- R6: A fetch or add to the address written by a store in the immediately preceding cycle returns the newly written word.
- R7: A store changes only the addressed word. All other words keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the result register |
| op_i | input | 2 | Operation code: 00 idle, 01 store, 10 fetch, 11 add |
| addr_i | input | 3 | Word address |
| data_i | input | 4 | Data word to store, or the second add operand |
| result_o | output | 5 | Registered result |

## Verification
The assertions assume that the op code, address and data inputs are known, two-valued values whenever reset is low. The memory reads combinationally, so an undefined address would make the assertion checks on fetch and add results meaningless. The bench drives every input on the falling edge to a defined value from reset onward. It stores a value into every word before its first fetch or add, so no check depends on the power-up memory contents, which are left undefined.

// File: rtl/memadd_pkg.sv
package memadd_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'b00,
      OP_STORE = 2'b01,
      OP_FETCH = 2'b10,
      OP_ADD   = 2'b11
   } memadd_op_t;
endpackage

// File: rtl/memadd_store.sv
module memadd_store #(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("memadd_store: ADDR_W out of range");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("memadd_store: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         words[addr] <= din;
      end
   end

   // Combinational read: a store at the previous edge is already visible.
   assign dout = words[addr];

   AST_STORE_LANDS: assert property (@(posedge clk) disable iff (rst)
      we |=> words[$past(addr)] == $past(din)); // R2
endmodule

// File: rtl/memadd_adder.sv
module memadd_adder #(
   parameter int DATA_W = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W:0]   sum
);
   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("memadd_adder: DATA_W must be positive");
      end

      if (RIPPLE) begin : g_ripple
         logic [DATA_W:0]   carry;
         logic [DATA_W-1:0] bits;
         assign carry[0] = 1'b0;
         for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign bits[i]    = a[i] ^ b[i] ^ carry[i];
            assign carry[i+1] = (a[i] & b[i]) | (carry[i] & (a[i] ^ b[i]));
         end
         assign sum = {carry[DATA_W], bits};
      end else begin : g_behav
         assign sum = {1'b0, a} + {1'b0, b};
      end
   endgenerate
endmodule

// File: rtl/memadd_result.sv
module memadd_result
   import memadd_pkg::*;
#(
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  memadd_op_t        op,
   input  logic [DATA_W-1:0] word,
   input  logic [DATA_W:0]   sum,
   output logic [DATA_W:0]   q
);
   localparam int RES_W = DATA_W + 1;

   logic [RES_W-1:0] q_next;

   always_comb begin
      q_next = q;
      unique case (op)
         OP_FETCH: q_next = {1'b0, word};
         OP_ADD:   q_next = sum;
         default:  q_next = q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else begin
         q <= q_next;
      end
   end

   logic rst_seen;
   always_ff @(posedge clk) rst_seen <= rst;

   always_comb begin
      if (rst_seen) begin
         AST_RESET_CLEARS: assert (q == '0); // R1
      end
   end

   AST_TOP_BIT_ZERO: assert property (@(posedge clk) disable iff (rst)
      op == OP_FETCH |=> q[DATA_W] == 1'b0); // R3
endmodule

// File: rtl/memadd_core.sv
module memadd_core
   import memadd_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 4,
   parameter bit RIPPLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        op_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W:0]   result_o
);
   localparam int RES_W = DATA_W + 1;

   memadd_op_t        op;
   logic              store_en;
   logic [DATA_W-1:0] rd_word;
   logic [RES_W-1:0]  sum;

   assign op       = memadd_op_t'(op_i);
   assign store_en = (op == OP_STORE);

   memadd_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_store (
      .clk  (clk),
      .rst  (rst),
      .we   (store_en),
      .addr (addr_i),
      .din  (data_i),
      .dout (rd_word)
   );

   memadd_adder #(.DATA_W(DATA_W), .RIPPLE(RIPPLE)) i_adder (
      .a   (rd_word),
      .b   (data_i),
      .sum (sum)
   );

   memadd_result #(.DATA_W(DATA_W)) i_result (
      .clk  (clk),
      .rst  (rst),
      .op   (op),
      .word (rd_word),
      .sum  (sum),
      .q    (result_o)
   );

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      op_i == 2'b00 |=> $stable(result_o)); // R5
   AST_HOLD_STORE: assert property (@(posedge clk) disable iff (rst)
      op_i == 2'b01 |=> $stable(result_o)); // R2
   AST_FETCH_WORD: assert property (@(posedge clk) disable iff (rst)
      op_i == 2'b10 |=> result_o == {1'b0, $past(rd_word)}); // R3
   AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
      op_i == 2'b11 |=> result_o == ({1'b0, $past(rd_word)} + {1'b0, $past(data_i)})); // R4
endmodule

// File: tb/test_memadd_core.sv
module test_memadd_core;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] op_i = 2'b00;
   logic [2:0] addr_i = '0;
   logic [3:0] data_i = '0;
   logic [4:0] result_o;

   int applied = 0;
   int bad     = 0;
   int ref_mem [8];
   int exp_q   = 0;

   always #2 clk = ~clk;

   memadd_core i_memadd_core (
      .clk(clk), .rst(rst), .op_i(op_i), .addr_i(addr_i),
      .data_i(data_i), .result_o(result_o)
   );

   task automatic check(input string req);
      applied++;
      if (int'(result_o) != exp_q) begin
         bad++;
         $display("FAIL %s: result=%0d expected=%0d", req, result_o, exp_q);
      end
   endtask

   // One cycle: drive at falling edge, update model at rising edge, compare 1 ns later.
   task automatic step(input logic r, input logic [1:0] op, input int a, input int d,
                       input string req);
      @(negedge clk);
      rst = r; op_i = op; addr_i = a[2:0]; data_i = d[3:0];
      @(posedge clk);
      if (r) exp_q = 0;
      else case (op)
         2'b01: ref_mem[a] = d;
         2'b10: exp_q = ref_mem[a];
         2'b11: exp_q = ref_mem[a] + d;
         default: ;
      endcase
      #1;
      check(req);
   endtask

   initial begin
      #400000;
      bad++;
      $display("FAIL watchdog: result=%0d expected=finish", result_o);
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
   end

   initial begin
      step(1, 2'b00, 0, 0, "R1");
      step(1, 2'b00, 0, 0, "R1");
      // Fill every word; result must stay 0 on stores (R2).
      for (int a = 0; a < 8; a++) step(0, 2'b01, a, (a * 5 + 3) % 16, "R2");
      for (int a = 0; a < 8; a++) step(0, 2'b10, a, 9, "R3");
      for (int a = 0; a < 8; a++) step(0, 2'b11, a, 15 - a, "R4");
      step(0, 2'b11, 3, 0, "R4");
      // Idle holds
      step(0, 2'b00, 5, 7, "R5");
      step(0, 2'b00, 1, 2, "R5");
      // Store then add same address: carry case 15 + 15 = 30 (R6, R4)
      step(0, 2'b01, 7, 15, "R2");
      step(0, 2'b11, 7, 15, "R6");
      if (exp_q != 30) begin bad++; $display("FAIL R4: model=%0d expected=30", exp_q); end
      step(0, 2'b01, 2, 6, "R2");
      step(0, 2'b10, 2, 0, "R6");
      // Store to 3 must not disturb 4 (R7)
      step(0, 2'b01, 3, 12, "R2");
      step(0, 2'b10, 4, 0, "R7");
      step(0, 2'b10, 3, 0, "R7");
      for (int a = 0; a < 8; a++) step(0, 2'b10, a, 0, "R7");
      // Fetch of a word with top data bit set keeps bit 4 at zero
      step(0, 2'b01, 0, 14, "R2");
      step(0, 2'b10, 0, 15, "R3");
      step(0, 2'b11, 0, 1, "R4");
      step(0, 2'b00, 0, 0, "R5");
      // Mid-run reset clears result, memory kept
      step(1, 2'b11, 0, 15, "R1");
      step(0, 2'b10, 0, 0, "R1");
      step(0, 2'b11, 6, 2, "R4");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
   end
endmodule